// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four peripheral channels gets the system bus for the next DMA transfer. Each channel raises a request line, and each request counts only while that channel's enable bit is set. When an enabled request is present the block asks the processor for the bus with a hold request. Once the processor answers with hold-acknowledge, the block drives exactly one channel acknowledge. It also publishes the granted channel's index, so that the address and count datapath next to it can select the right registers.

The bus owner changes only at transfer-cycle boundaries, which the datapath marks with a one-cycle end-of-cycle pulse. At each boundary the block either grants the next winner at once, gives the bus back, or drops the acknowledge and waits for hold-acknowledge again. Two priority schemes are available. Fixed priority favours the lowest channel number. Rotating priority makes the channel just granted the least favoured one.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the hold request is low, all acknowledges are low and the grant index is 0. Reset clears the internal channel enables, so a request is not acted on until its enable bit has been sampled by a clock edge after reset.
- R2: Bit i of the enable input gates request line i. The enable input is sampled into an internal register on every clock edge and takes effect one edge later. A request from a disabled channel never raises the hold request and is never acknowledged.
- R3: When an enabled request is present and the block is idle, the hold request goes high after the next clock edge. It stays high for as long as any acknowledge is driven.
- R4: No acknowledge is driven until hold-acknowledge has been sampled high at a clock edge while the hold request is up. The acknowledge appears after that edge.
- R5: With the mode input low (fixed priority), channel 0 has the highest priority and channel 3 the lowest.
- R6: With the mode input high (rotating priority), the search starts at the channel after the last granted one, in ascending order and wrapping from 3 to 0. The last granted channel is the lowest priority. After reset, the last granted channel counts as channel 3.
- R7: The acknowledges are one-hot or all low. While an acknowledge is high, the grant index equals its bit position. With no acknowledge, the grant index is 0.
- R8: Once an acknowledge is driven, it and the grant index hold steady until the edge at which end-of-cycle is sampled high. Request changes in between do not affect them.
- R9: At an end-of-cycle edge, one of three things happens. With no enabled request left, the block drops the hold request and all acknowledges. With an enabled request and hold-acknowledge high, it grants the new winner directly. With an enabled request but hold-acknowledge low, it drops the acknowledges, keeps the hold request and waits.
- R10: If every enabled request disappears while the block waits for hold-acknowledge, the hold request drops after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| chanReq | input | 4 | Per-channel DMA request lines |
| chanEnable | input | 4 | Per-channel enable bits, bit i for channel i |
| rotateMode | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| holdAck | input | 1 | Processor has released the bus |
| cycleDone | input | 1 | One-cycle pulse at the end of a transfer cycle |
| holdReq | output | 1 | Bus request to the processor |
| chanAck | output | 4 | One-hot channel acknowledges |
| grantIdx | output | 2 | Index of the granted channel |

## Verification
Every output is registered. A change on the request, hold-acknowledge or end-of-cycle inputs therefore shows up one edge later. An enable change takes one extra edge, because the enable passes through its own register first. The bench drives all inputs on the falling edge and updates its behavioural model on the rising edge, applying exactly these latencies. It compares the three outputs with the model on every falling edge, so each result is checked in the first cycle it is due. Dedicated checks on fixed-priority winners, on the visiting order under rotation, and on acknowledges that stay stable across request changes within a cycle are taken at those same falling edges.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SERVE
  } arbState_t;

  typedef struct packed {
    logic grantLoad;
    logic grantClear;
    logic holdSet;
    logic holdClear;
  } arbStrobe_t;
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       holdAck,
  input  logic       cycleDone,
  output arbStrobe_t strobe
);
  arbState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (anyReq) begin
          strobe.holdSet = 1'b1;
          stateD = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!anyReq) begin
          strobe.holdClear = 1'b1;
          stateD = ST_IDLE;
        end else if (holdAck) begin
          strobe.grantLoad = 1'b1;
          stateD = ST_SERVE;
        end
      end
      ST_SERVE: begin
        if (cycleDone) begin
          if (!anyReq) begin
            strobe.grantClear = 1'b1;
            strobe.holdClear = 1'b1;
            stateD = ST_IDLE;
          end else if (holdAck) begin
            strobe.grantLoad = 1'b1;
          end else begin
            strobe.grantClear = 1'b1;
            stateD = ST_WAIT;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NumCh = 4,
  parameter int IdxW  = $clog2(NumCh)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NumCh-1:0] chanReq,
  input  logic [NumCh-1:0] chanEnable,
  input  logic             rotateMode,
  input  arbStrobe_t       strobe,
  output logic             anyReq,
  output logic             holdReq,
  output logic [NumCh-1:0] chanAck,
  output logic [IdxW-1:0]  grantIdx
);
  localparam logic [IdxW-1:0] LastInit = IdxW'(NumCh - 1);

  logic [NumCh-1:0] enableQ;
  logic [NumCh-1:0] effReq;
  logic [IdxW-1:0]  lastQ;
  logic [IdxW-1:0]  winIdx;
  logic             holdQ;
  logic [NumCh-1:0] ackQ;
  logic [IdxW-1:0]  idxQ;
  int               startPos;

  assign effReq = chanReq & enableQ;
  assign anyReq = |effReq;

  // Walk from the lowest-priority position down to the start so that
  // the first eligible channel in search order is the last one written.
  always_comb begin
    winIdx   = '0;
    startPos = rotateMode ? (int'(lastQ) + 1) % NumCh : 0;
    for (int k = NumCh - 1; k >= 0; k--) begin
      if (effReq[(startPos + k) % NumCh]) winIdx = IdxW'((startPos + k) % NumCh);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      lastQ   <= LastInit;
      holdQ   <= 1'b0;
      ackQ    <= '0;
      idxQ    <= '0;
    end else begin
      enableQ <= chanEnable;
      if (strobe.holdSet)        holdQ <= 1'b1;
      else if (strobe.holdClear) holdQ <= 1'b0;
      if (strobe.grantLoad) begin
        ackQ         <= '0;
        ackQ[winIdx] <= 1'b1;
        idxQ         <= winIdx;
        lastQ        <= winIdx;
      end else if (strobe.grantClear) begin
        ackQ <= '0;
        idxQ <= '0;
      end
    end
  end

  assign holdReq  = holdQ;
  assign chanAck  = ackQ;
  assign grantIdx = idxQ;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NumCh = 4,
  parameter int IdxW  = $clog2(NumCh)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NumCh-1:0] chanReq,
  input  logic [NumCh-1:0] chanEnable,
  input  logic             rotateMode,
  input  logic             holdAck,
  input  logic             cycleDone,
  output logic             holdReq,
  output logic [NumCh-1:0] chanAck,
  output logic [IdxW-1:0]  grantIdx
);
  arbStrobe_t strobe;
  logic       anyReq;

  dma_arb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyReq    (anyReq),
    .holdAck   (holdAck),
    .cycleDone (cycleDone),
    .strobe    (strobe)
  );

  dma_arb_datapath #(
    .NumCh (NumCh),
    .IdxW  (IdxW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .chanReq    (chanReq),
    .chanEnable (chanEnable),
    .rotateMode (rotateMode),
    .strobe     (strobe),
    .anyReq     (anyReq),
    .holdReq    (holdReq),
    .chanAck    (chanAck),
    .grantIdx   (grantIdx)
  );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NumCh = 4,
  parameter int IdxW  = $clog2(NumCh)
) (
  input logic             clk,
  input logic             rstN,
  input logic             holdAck,
  input logic             cycleDone,
  input logic             holdReq,
  input logic [NumCh-1:0] chanAck,
  input logic [IdxW-1:0]  grantIdx
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!holdReq && chanAck == '0 && grantIdx == '0));

  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanAck));

  assert_idx_matches_R7: assert property (@(posedge clk) disable iff (!rstN)
    (chanAck != '0) |-> chanAck[grantIdx]);

  assert_ack_under_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chanAck != '0) |-> holdReq);

  assert_ack_after_holdack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chanAck != '0 && chanAck != $past(chanAck)) |-> ($past(holdAck) && $past(holdReq)));

  assert_grant_at_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chanAck) != '0 && !$past(cycleDone)) |-> ($stable(chanAck) && $stable(grantIdx)));
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(
  .NumCh (NumCh),
  .IdxW  (IdxW)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .holdAck   (holdAck),
  .cycleDone (cycleDone),
  .holdReq   (holdReq),
  .chanAck   (chanAck),
  .grantIdx  (grantIdx)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb_top;
  localparam int ClkPeriod = 10;
  localparam int WatchCycles = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] chanReq = '0;
  logic [3:0] chanEnable = '0;
  logic       rotateMode = 1'b0;
  logic       holdAck = 1'b0;
  logic       cycleDone = 1'b0;
  logic       holdReq;
  logic [3:0] chanAck;
  logic [1:0] grantIdx;

  int    nChecks = 0;
  int    nFails = 0;
  string phaseTag = "R1";
  bit    autoAck = 1'b0;
  bit    finished = 1'b0;

  always #(ClkPeriod / 2) clk = ~clk;

  dma_req_arbiter dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .chanReq    (chanReq),
    .chanEnable (chanEnable),
    .rotateMode (rotateMode),
    .holdAck    (holdAck),
    .cycleDone  (cycleDone),
    .holdReq    (holdReq),
    .chanAck    (chanAck),
    .grantIdx   (grantIdx)
  );

  // Behavioural reference: 0 idle, 1 waiting for the bus, 2 serving.
  int       mState;
  bit       mHold;
  bit [3:0] mAck;
  int       mIdx;
  int       mLast;
  bit [3:0] mEn;
  bit [3:0] mEff;
  int       mOrder[$];
  int       mPick;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mHold = 0; mAck = '0; mIdx = 0; mLast = 3; mEn = '0;
    end else begin
      mEff = chanReq & mEn;
      mOrder = {};
      for (int k = 0; k < 4; k++)
        mOrder.push_back(((rotateMode ? mLast + 1 : 0) + k) % 4);
      mPick = -1;
      foreach (mOrder[j]) if (mPick < 0 && mEff[mOrder[j]]) mPick = mOrder[j];
      case (mState)
        0: if (mPick >= 0) begin mHold = 1; mState = 1; end
        1: if (mPick < 0) begin mHold = 0; mState = 0; end
           else if (holdAck) begin
             mAck = 4'b1 << mPick; mIdx = mPick; mLast = mPick; mState = 2;
           end
        default: if (cycleDone) begin
          if (mPick < 0) begin mAck = '0; mIdx = 0; mHold = 0; mState = 0; end
          else if (holdAck) begin mAck = 4'b1 << mPick; mIdx = mPick; mLast = mPick; end
          else begin mAck = '0; mIdx = 0; mState = 1; end
        end
      endcase
      mEn = chanEnable;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      nChecks++;
      if (holdReq !== mHold || chanAck !== mAck || grantIdx !== 2'(mIdx)) begin
        nFails++;
        $display("FAIL %s: hold/ack/idx actual %b/%b/%0d expected %b/%b/%0d",
                 phaseTag, holdReq, chanAck, grantIdx, mHold, mAck, mIdx);
      end
      if (autoAck) holdAck <= holdReq;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic endCycle();
    @(negedge clk) cycleDone = 1'b1;
    @(negedge clk) cycleDone = 1'b0;
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(ClkPeriod * WatchCycles);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int seen;
    int prevIdx;
    // R1: inputs active during reset, outputs must stay quiet
    chanReq = 4'hF; chanEnable = 4'hF; holdAck = 1'b1;
    ticks(3);
    check(holdReq == 0 && chanAck == 0 && grantIdx == 0, "R1", chanAck, 0);
    rstN = 1'b1;
    ticks(1);
    check(holdReq == 0, "R1", holdReq, 0);
    chanReq = '0; holdAck = 1'b0; chanEnable = '0;
    ticks(4);

    // R2: requests from disabled channels
    phaseTag = "R2";
    chanReq = 4'hF; chanEnable = 4'h0;
    ticks(4);
    check(holdReq == 0, "R2", holdReq, 0);
    chanEnable = 4'b0100; chanReq = 4'b0011;
    ticks(4);
    check(holdReq == 0, "R2", holdReq, 0);
    autoAck = 1'b1;
    chanReq = 4'b0111;
    ticks(4);
    check(chanAck == 4'b0100, "R2", chanAck, 4'b0100);
    chanReq = '0;
    endCycle();
    ticks(2);

    // R4: hold request without hold-acknowledge
    phaseTag = "R4";
    autoAck = 1'b0; holdAck = 1'b0;
    chanEnable = 4'hF; chanReq = 4'b1000;
    ticks(6);
    check(holdReq == 1 && chanAck == 0, "R4", chanAck, 0);
    holdAck = 1'b1;
    ticks(1);
    check(chanAck == 4'b1000 && grantIdx == 3, "R4", grantIdx, 3);

    // R8: requests change mid-cycle, grant holds
    phaseTag = "R8";
    chanReq = 4'b1001;
    ticks(3);
    check(chanAck == 4'b1000, "R8", chanAck, 4'b1000);
    chanReq = 4'b0001;
    ticks(2);
    check(grantIdx == 3, "R8", grantIdx, 3);

    // R9: boundary with a pending request and hold-acknowledge high
    phaseTag = "R9";
    endCycle();
    check(chanAck == 4'b0001, "R9", chanAck, 4'b0001);
    // boundary with hold-acknowledge low: drop ack, keep hold
    holdAck = 1'b0;
    endCycle();
    check(chanAck == 0 && holdReq == 1, "R9", chanAck, 0);

    // R10: request vanishes while waiting
    phaseTag = "R10";
    chanReq = '0;
    ticks(2);
    check(holdReq == 0, "R10", holdReq, 0);

    // R5: fixed priority
    phaseTag = "R5";
    autoAck = 1'b1; rotateMode = 1'b0; chanReq = 4'hF;
    ticks(4);
    check(grantIdx == 0, "R5", grantIdx, 0);
    endCycle();
    check(grantIdx == 0, "R5", grantIdx, 0);
    chanReq = 4'b1110;
    endCycle();
    check(grantIdx == 1, "R5", grantIdx, 1);
    chanReq = 4'b1100;
    endCycle();
    check(grantIdx == 2, "R5", grantIdx, 2);

    // R6: rotating priority visits every channel in ascending order
    phaseTag = "R6";
    rotateMode = 1'b1; chanReq = 4'hF;
    seen = 0;
    prevIdx = grantIdx;
    for (int n = 0; n < 4; n++) begin
      endCycle();
      check(grantIdx == (prevIdx + 1) % 4, "R6", grantIdx, (prevIdx + 1) % 4);
      prevIdx = grantIdx;
      seen |= 1 << grantIdx;
    end
    check(seen == 15, "R6", seen, 15);
    chanReq = 4'b0101;
    endCycle();
    ticks(1);
    endCycle();
    ticks(1);

    // R7 / R3: closing a transfer with nothing left
    phaseTag = "R7";
    chanReq = '0;
    endCycle();
    check(chanAck == 0 && grantIdx == 0 && holdReq == 0, "R7", chanAck, 0);
    phaseTag = "R3";
    chanReq = 4'b0010;
    ticks(1);
    check(holdReq == 1, "R3", holdReq, 1);
    chanReq = '0;
    endCycle();
    ticks(3);
    finishRun();
  end
endmodule